// File: doc/BRIEF.md
# Peripheral Clock Source Mux with Half-Step Divider

This block makes one peripheral clock-enable strobe out of a group of parent tick strobes. All of them live in a single fast system clock domain. A control word picks which parent drives the output. The same word also sets a divide ratio that carries one fractional bit, so the ratio moves in steps of one half. The output rate is twice the parent rate divided by (field + 2). A field of zero therefore passes the parent straight through, and a field of one keeps two parent ticks out of every three.

The divide is done by an accumulator. It gains two on every tick of the selected parent. When it reaches the threshold (field + 2), it emits an output tick and gives back the threshold. A new control word is not applied at once: it is held as a pending change and applied only at an output tick. If the word changes both the divider and the source, the divider goes first and the source follows at the next output tick. Where the select field sits in the word, and how wide it is, depends on a per-instance format parameter. Codes that name no wired parent are refused.

Top module: `pclk_halfstep_div`

## Requirements
- R1: With a divider field of 0, every tick of the selected parent gives an output tick on `tick_o`. The output tick appears one clock after the parent tick.
- R2: The accumulator starts from zero at each applied change. After such a start, N ticks of the selected parent give exactly floor(2N / (field + 2)) output ticks. Field 1 gives 2 output ticks per 3 parent ticks, and field 6 gives 1 per 4.
- R3: The divider field is the low DIV_W bits of the control word, 8 bits by default. The maximum field of 255 gives one output tick per 128.5 parent ticks, and it reads back as 255.
- R4: In the default format the source select is bits 31:29 of the control word. Code k selects `par_tick_i[k]`.
- R5: By default only codes 0 to 4 are valid (VALID_MASK bit set). A write that carries an invalid code leaves the active and pending source unchanged. The divider part of that same write is still taken.
- R6: A written value changes neither `div_eff_o` nor `src_eff_o` until an output tick occurs. Both readbacks update in the clock right after that tick's edge. A write that equals the active value cancels any pending change to that field.
- R7: When one write changes both fields, the divider is applied at the first output tick and the source at the following output tick. The two are never applied at the same edge.
- R8: Once a new source is applied, ticks on any other parent input produce no output ticks.
- R9: While `rst_n` is low, `tick_o` stays 0 and both readbacks are 0, whatever the parent inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Write strobe for the control word |
| ctrl_word_i | input | 32 | Control word: divider in the low bits, select field placed by format |
| par_tick_i | input | NUM_PAR | One tick strobe per parent clock |
| tick_o | output | 1 | Divided output tick strobe |
| div_eff_o | output | DIV_W | Divider field currently in effect |
| src_eff_o | output | IDX_W | Source index currently in effect |

## Verification
The hardest case to reach is a write that changes both fields. The bench has to see the divider applied on its own at one output tick and the source applied at the next, without either change landing early. To get there, it first sets a small divider so that output ticks come often. It then writes a combined change and pulses only the old parent, one tick at a time. After each pulse it reads both readbacks, so it sees the state between the two boundaries. It keeps pulsing the old parent until the source switches, and then shows that the old parent has gone silent at the output.

// File: rtl/pclk_div_pkg.sv
package pclk_div_pkg;

  // Placement of the source select field inside the 32-bit control word
  typedef enum logic [1:0] {
    SELF_HI2  = 2'd0,   // bits 31:30, four codes
    SELF_HI3  = 2'd1,   // bits 31:29, up to eight codes
    SELF_MID2 = 2'd2    // bits 29:28, four codes
  } sel_fmt_e;

  function automatic int sel_lsb(sel_fmt_e f);
    case (f)
      SELF_HI2:  return 30;
      SELF_HI3:  return 29;
      default:   return 28;
    endcase
  endfunction

  function automatic int sel_width(sel_fmt_e f);
    return (f == SELF_HI3) ? 3 : 2;
  endfunction

endpackage

// File: rtl/clkdiv_src_pick.sv
module clkdiv_src_pick #(
  parameter int NUM_PAR = 8,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_PAR-1:0] par_tick_i,
  input  logic [IDX_W-1:0]   src_i,
  output logic               hit_o
);
  logic [NUM_PAR-1:0] gated;

  for (genvar i = 0; i < NUM_PAR; i++) begin : g_gate
    assign gated[i] = par_tick_i[i] & (src_i == IDX_W'(i));
  end

  assign hit_o = |gated;
endmodule

// File: rtl/clkdiv_half_acc.sv
module clkdiv_half_acc #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic [DIV_W-1:0] field_i,
  input  logic             restart_i,
  output logic             fire_o,
  output logic             tick_o
);
  localparam int ACC_W = DIV_W + 2;

  function automatic logic [ACC_W-1:0] thr_of(logic [DIV_W-1:0] f);
    return ACC_W'(f) + ACC_W'(2);
  endfunction

  function automatic logic [ACC_W-1:0] step_up(logic [ACC_W-1:0] a);
    return a + ACC_W'(2);
  endfunction

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] thr;

  assign thr    = thr_of(field_i);
  assign sum    = step_up(acc_q);
  assign fire_o = hit_i & (sum >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= fire_o;
      if (restart_i)
        acc_q <= '0;
      else if (hit_i)
        acc_q <= fire_o ? (sum - thr) : sum;
    end
  end

  // R2: the remainder stays below the threshold of the active field
  p_acc_below_thr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < thr);

  // R1: a field of zero turns every parent tick into an output tick
  p_pass_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && field_i == '0) |=> tick_o);
endmodule

// File: rtl/clkdiv_cfg_stage.sv
module clkdiv_cfg_stage #(
  parameter int                 NUM_PAR    = 8,
  parameter int                 IDX_W      = 3,
  parameter int                 DIV_W      = 8,
  parameter int                 SEL_LSB    = 29,
  parameter int                 SEL_W      = 3,
  parameter logic [NUM_PAR-1:0] VALID_MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [31:0]      word_i,
  input  logic             fire_i,
  output logic [DIV_W-1:0] div_act_o,
  output logic [IDX_W-1:0] src_act_o,
  output logic             apply_o
);
  logic [SEL_W-1:0] sel_raw;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_ok;
  logic [DIV_W-1:0] div_new;
  logic [DIV_W-1:0] div_pend;
  logic [IDX_W-1:0] src_pend;
  logic             div_pv;
  logic             src_pv;
  logic             apply_div;
  logic             apply_src;
  logic [DIV_W-1:0] div_next;
  logic [IDX_W-1:0] src_next;

  assign sel_raw = word_i[SEL_LSB +: SEL_W];
  assign sel_idx = IDX_W'(sel_raw);
  assign sel_ok  = VALID_MASK[sel_idx];
  assign div_new = word_i[DIV_W-1:0];

  // Divider goes first; the source waits for a boundary with no divider pending
  assign apply_div = fire_i & div_pv;
  assign apply_src = fire_i & src_pv & ~div_pv;
  assign apply_o   = apply_div | apply_src;
  assign div_next  = apply_div ? div_pend : div_act_o;
  assign src_next  = apply_src ? src_pend : src_act_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act_o <= '0;
      src_act_o <= '0;
      div_pend  <= '0;
      src_pend  <= '0;
      div_pv    <= 1'b0;
      src_pv    <= 1'b0;
    end else begin
      div_act_o <= div_next;
      src_act_o <= src_next;
      if (wr_i) begin
        div_pend <= div_new;
        div_pv   <= (div_new != div_next);
      end else if (apply_div) begin
        div_pv   <= 1'b0;
      end
      if (wr_i && sel_ok) begin
        src_pend <= sel_idx;
        src_pv   <= (sel_idx != src_next);
      end else if (apply_src) begin
        src_pv   <= 1'b0;
      end
    end
  end

  // R5: the active source is always a wired, valid code
  p_src_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    VALID_MASK[src_act_o]);

  // R6: settings move only on an output-tick boundary
  p_change_on_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act_o != $past(div_act_o) || src_act_o != $past(src_act_o)) |-> $past(fire_i));

  // R7: never both fields at the same edge
  p_one_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_act_o != $past(div_act_o) && src_act_o != $past(src_act_o)));
endmodule

// File: rtl/pclk_halfstep_div.sv
module pclk_halfstep_div
  import pclk_div_pkg::*;
#(
  parameter int                 NUM_PAR    = 8,
  parameter int                 DIV_W      = 8,
  parameter sel_fmt_e           SEL_FMT    = SELF_HI3,
  parameter logic [NUM_PAR-1:0] VALID_MASK = 8'h1F,
  localparam int                IDX_W      = $clog2(NUM_PAR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr_i,
  input  logic [31:0]        ctrl_word_i,
  input  logic [NUM_PAR-1:0] par_tick_i,
  output logic               tick_o,
  output logic [DIV_W-1:0]   div_eff_o,
  output logic [IDX_W-1:0]   src_eff_o
);
  localparam int SEL_LSB = sel_lsb(SEL_FMT);
  localparam int SEL_W   = sel_width(SEL_FMT);

  logic parent_hit;
  logic fire;
  logic apply;

  clkdiv_src_pick #(.NUM_PAR(NUM_PAR), .IDX_W(IDX_W)) u_pick (
    .par_tick_i (par_tick_i),
    .src_i      (src_eff_o),
    .hit_o      (parent_hit)
  );

  clkdiv_half_acc #(.DIV_W(DIV_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_i     (parent_hit),
    .field_i   (div_eff_o),
    .restart_i (apply),
    .fire_o    (fire),
    .tick_o    (tick_o)
  );

  clkdiv_cfg_stage #(
    .NUM_PAR(NUM_PAR), .IDX_W(IDX_W), .DIV_W(DIV_W),
    .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .VALID_MASK(VALID_MASK)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (ctrl_wr_i),
    .word_i    (ctrl_word_i),
    .fire_i    (fire),
    .div_act_o (div_eff_o),
    .src_act_o (src_eff_o),
    .apply_o   (apply)
  );

  // R8: each output tick traces back to a tick of the selected parent
  p_tick_from_parent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(parent_hit));
endmodule

// File: tb/pclk_halfstep_div_tb.sv
module pclk_halfstep_div_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] word = '0;
  logic [7:0]  par = '0;
  logic        tick;
  logic [7:0]  div_eff;
  logic [2:0]  src_eff;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  int exp_q[$];

  pclk_halfstep_div u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(wr), .ctrl_word_i(word),
    .par_tick_i(par), .tick_o(tick), .div_eff_o(div_eff), .src_eff_o(src_eff)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (tick) tick_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic write_cfg(input int sel, input int field);
    word = (32'(sel) << 29) | 32'(field);
    wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse(input int idx);
    par[idx] = 1'b1;
    @(negedge clk);
    par = '0;
    @(negedge clk);
  endtask

  task automatic settle(input int sel, input int field);
    for (int k = 0; k < 700; k++) begin
      if (int'(src_eff) == sel && int'(div_eff) == field) break;
      pulse(int'(src_eff));
    end
  endtask

  // driver pushes the expected count, monitor side pops and compares
  task automatic window(input int idx, input int field, input int n, input string req);
    int got, exp;
    exp_q.push_back((2 * n) / (field + 2));
    tick_cnt = 0;
    repeat (n) pulse(idx);
    got = tick_cnt;
    exp = exp_q.pop_front();
    check(got == exp, req, got, exp);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    tick_cnt = 0;
    repeat (3) @(negedge clk);
    pulse(0);
    // R9 reset state
    check(tick == 1'b0 && tick_cnt == 0, "R9", tick_cnt, 0);
    check(div_eff == 8'd0, "R9", int'(div_eff), 0);
    check(src_eff == 3'd0, "R9", int'(src_eff), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 pass-through
    window(0, 0, 20, "R1");

    // R6 hold until an output tick, then apply
    write_cfg(0, 1);
    repeat (5) @(negedge clk);
    check(div_eff == 8'd0, "R6", int'(div_eff), 0);
    settle(0, 1);
    check(div_eff == 8'd1, "R6", int'(div_eff), 1);
    window(0, 1, 30, "R2");

    write_cfg(0, 6);
    settle(0, 6);
    window(0, 6, 40, "R2");

    // R3 maximum field
    write_cfg(0, 255);
    settle(0, 255);
    check(div_eff == 8'd255, "R3", int'(div_eff), 255);
    window(0, 255, 300, "R3");

    write_cfg(0, 2);
    settle(0, 2);

    // R7 combined change: divider first, source one boundary later
    write_cfg(3, 4);
    for (int k = 0; k < 100; k++) begin
      if (div_eff == 8'd4) break;
      pulse(0);
    end
    check(div_eff == 8'd4 && src_eff == 3'd0, "R7", int'(src_eff), 0);
    for (int k = 0; k < 100; k++) begin
      if (src_eff == 3'd3) break;
      pulse(0);
    end
    check(src_eff == 3'd3 && div_eff == 8'd4, "R7", int'(src_eff), 3);
    window(3, 4, 24, "R4");

    // R8 old parent no longer drives the output
    tick_cnt = 0;
    repeat (30) pulse(0);
    check(tick_cnt == 0, "R8", tick_cnt, 0);

    // R5 invalid code 6 refused, divider part taken
    write_cfg(6, 0);
    settle(3, 0);
    check(div_eff == 8'd0, "R5", int'(div_eff), 0);
    check(src_eff == 3'd3, "R5", int'(src_eff), 3);
    window(3, 0, 10, "R5");

    // R9 reset while parents keep ticking
    write_cfg(0, 5);
    @(negedge clk);
    rst_n = 1'b0;
    tick_cnt = 0;
    repeat (10) pulse(3);
    repeat (10) pulse(0);
    check(tick_cnt == 0, "R9", tick_cnt, 0);
    check(div_eff == 8'd0 && src_eff == 3'd0, "R9", int'(div_eff), 0);
    rst_n = 1'b1;
    @(negedge clk);
    window(0, 0, 8, "R9");

    finish_run();
  end
endmodule